// File: doc/BRIEF.md
# Indirect Register and Cursor Pattern Access Port

This block gives a byte-wide host indirect access to a small cursor controller. The host first loads an internal 9-bit pointer through two address ports. It then uses one of two data ports. The control data port moves one byte to or from the control register file. The pattern data port moves one 16-bit word to or from a 512-word cursor pattern RAM. Every data-port access, read or write, advances the pointer by one. A run of consecutive registers or pattern words therefore needs only one pointer setup.

The stored control values are decoded and driven as outputs to a pixel engine. These outputs are a command byte split into its fields, a 12-bit cursor position, and four 16-bit crosshair window values. The pixel engine also has a private read port into the pattern RAM. The host uses a single-cycle write or read strobe. Read data comes back one clock later, together with a valid flag.

Top module: `cursor_regport`

## Requirements
- R1: After reset the pointer is 0x000 and every control output (command fields, cursor X/Y, window X/Y/width/height) is zero, so the cursor is off.
- R2: `host_port` selects the host port: 0 = pointer low, 1 = pointer high, 2 = control data, 3 = pattern data. A write to port 0 loads pointer bits 7:0 from `host_wdata[7:0]`. A write to port 1 loads pointer bit 8 from `host_wdata[0]`. Reading port 0 returns pointer bits 7:0, and reading port 1 returns pointer bit 8 in bit 0 with all other bits zero. Accesses to ports 0 and 1 never advance the pointer.
- R3: A write on port 2 stores `host_wdata[7:0]` in the control register selected by the pointer, then increments the pointer by one.
- R4: A read on port 2 returns the selected control register in `host_rdata[7:0]` with `host_rdata[15:8]` zero, then increments the pointer by one.
- R5: Control register indices: 0 command; 1/2 cursor X low/high; 3/4 cursor Y low/high; 5/6 window X low/high; 7/8 window Y low/high; 9/10 window width low/high; 11/12 window height low/high. The cursor X and Y high registers keep only bits 3:0, so each cursor coordinate is 12 bits. Their upper bits read back as zero.
- R6: At pointer values above 0x00C, a write on port 2 changes no register and a read on port 2 returns zero. The pointer still advances.
- R7: A write on port 3 stores all 16 bits of `host_wdata` in the pattern word at the pointer, and a read on port 3 returns that word. Both then increment the pointer by one.
- R8: The pointer wraps from 0x1FF to 0x000 on increment.
- R9: Byte-wide ports (0, 1, 2) ignore `host_wdata[15:8]`.
- R10: `pix_data` is the pattern word at `pix_addr`, one clock after `pix_addr` is sampled.
- R11: Command bits drive the outputs: bit 6 `cur_en`, bit 5 `xhair_en`, bit 4 `or_mode`, bits 3:2 `mux_sel`, bits 1:0 `thick`.
- R12: `host_rvalid` is high in the cycle after a read strobe and low otherwise. When `host_wr` and `host_rd` are both high, only the write takes place, with one pointer step and no read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_port | input | 2 | Host port select |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid |
| pix_addr | input | 9 | Pixel engine pattern read address |
| pix_data | output | 16 | Pattern word for pix_addr |
| cur_en | output | 1 | Cursor enable |
| xhair_en | output | 1 | Crosshair enable |
| or_mode | output | 1 | Combine cursors by OR (0 = XOR) |
| mux_sel | output | 2 | Pixel multiplex select |
| thick | output | 2 | Crosshair thickness code |
| cur_x | output | 12 | Cursor X |
| cur_y | output | 12 | Cursor Y |
| win_x | output | 16 | Window X |
| win_y | output | 16 | Window Y |
| win_w | output | 16 | Window width |
| win_h | output | 16 | Window height |

## Verification
The main internal hazard is a pointer that is wrong by one step. Such a pointer shows up on the very next data access: the data lands in a neighbouring register or word, or is read back from one. Reading the pointer ports exposes it directly, in the cycle after the read. A decode error in the register file shows on the decoded outputs right after the write edge. Out-of-range writes are checked by confirming that all outputs remain unchanged. Wrap errors show when a 512-word fill does not return the pointer to zero.

// File: rtl/cursor_regport_pkg.sv
package cursor_regport_pkg;

    typedef enum logic [1:0] {
        HP_PTR_LO = 2'd0,
        HP_PTR_HI = 2'd1,
        HP_CTL    = 2'd2,
        HP_PAT    = 2'd3
    } hport_e;

    localparam int NREG     = 13;
    localparam int IX_CMD   = 0;
    localparam int IX_CXLO  = 1;
    localparam int IX_CXHI  = 2;
    localparam int IX_CYLO  = 3;
    localparam int IX_CYHI  = 4;
    localparam int IX_WXLO  = 5;
    localparam int IX_WXHI  = 6;
    localparam int IX_WYLO  = 7;
    localparam int IX_WYHI  = 8;
    localparam int IX_WWLO  = 9;
    localparam int IX_WWHI  = 10;
    localparam int IX_WHLO  = 11;
    localparam int IX_WHHI  = 12;
    localparam int COORD_HI_BITS = 4;

    function automatic logic [7:0] keep_mask(input int idx);
        if (idx == IX_CXHI || idx == IX_CYHI)
            return 8'((1 << COORD_HI_BITS) - 1);
        return 8'hFF;
    endfunction

endpackage

// File: rtl/cursor_ptr.sv
module cursor_ptr #(
    parameter int PTR_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_lo,
    input  logic                 ld_hi,
    input  logic [7:0]           lo_byte,
    input  logic [PTR_W-9:0]     hi_bits,
    input  logic                 adv,
    output logic [PTR_W-1:0]     ptr
);
    localparam int HI_W = PTR_W - 8;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_lo)
            st_d.ptr[7:0] = lo_byte;
        if (ld_hi)
            st_d.ptr[PTR_W-1:8] = hi_bits[HI_W-1:0];
        if (adv)
            st_d.ptr = st_q.ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign ptr = st_q.ptr;

endmodule

// File: rtl/cursor_ctlfile.sv
module cursor_ctlfile
    import cursor_regport_pkg::*;
#(
    parameter int PTR_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PTR_W-1:0]       idx,
    input  logic [7:0]             wbyte,
    output logic [7:0]             rbyte,
    output logic [NREG-1:0][7:0]   regs
);
    typedef struct packed {
        logic [NREG-1:0][7:0] regs;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && idx == PTR_W'(i))
                st_d.regs[i] = wbyte & keep_mask(i);
        end
    end

    always_comb begin
        rbyte = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == PTR_W'(i))
                rbyte = st_q.regs[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign regs = st_q.regs;

endmodule

// File: rtl/cursor_patram.sv
module cursor_patram #(
    parameter int DEPTH = 512,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic [AW-1:0] p_addr,
    output logic [DW-1:0] p_rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (h_we)
            mem[h_addr] <= h_wdata;
        h_rdata <= mem[h_addr];
        p_rdata <= mem[p_addr];
    end

endmodule

// File: rtl/cursor_regport.sv
module cursor_regport
    import cursor_regport_pkg::*;
#(
    parameter int PTR_W = 9,
    parameter int DW    = 16,
    parameter int CW    = 12,
    localparam int DEPTH = 1 << PTR_W,
    localparam int HI_W  = PTR_W - 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       host_port,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    output logic             host_rvalid,
    input  logic [PTR_W-1:0] pix_addr,
    output logic [DW-1:0]    pix_data,
    output logic             cur_en,
    output logic             xhair_en,
    output logic             or_mode,
    output logic [1:0]       mux_sel,
    output logic [1:0]       thick,
    output logic [CW-1:0]    cur_x,
    output logic [CW-1:0]    cur_y,
    output logic [15:0]      win_x,
    output logic [15:0]      win_y,
    output logic [15:0]      win_w,
    output logic [15:0]      win_h
);
    typedef struct packed {
        logic       rvalid;
        logic       from_pat;
        logic [7:0] rbyte;
    } rd_t;

    rd_t rd_d, rd_q;

    logic                 rd_eff;
    logic                 ld_lo, ld_hi, adv;
    logic                 ctl_we, pat_we;
    logic [PTR_W-1:0]     ptr_q;
    logic [7:0]           ctl_rbyte;
    logic [NREG-1:0][7:0] regs;
    logic [DW-1:0]        pat_rdata;
    hport_e               sel;

    always_comb begin
        sel    = hport_e'(host_port);
        rd_eff = host_rd && !host_wr;
        ld_lo  = host_wr && sel == HP_PTR_LO;
        ld_hi  = host_wr && sel == HP_PTR_HI;
        ctl_we = host_wr && sel == HP_CTL;
        pat_we = host_wr && sel == HP_PAT;
        adv    = (host_wr || rd_eff) && (sel == HP_CTL || sel == HP_PAT);
    end

    always_comb begin
        rd_d          = '0;
        rd_d.rvalid   = rd_eff;
        rd_d.from_pat = rd_eff && sel == HP_PAT;
        unique case (sel)
            HP_PTR_LO: rd_d.rbyte = ptr_q[7:0];
            HP_PTR_HI: rd_d.rbyte = 8'(ptr_q[PTR_W-1:8]);
            HP_CTL:    rd_d.rbyte = ctl_rbyte;
            default:   rd_d.rbyte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_d;
    end

    cursor_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .lo_byte (host_wdata[7:0]),
        .hi_bits (host_wdata[HI_W-1:0]),
        .adv     (adv),
        .ptr     (ptr_q)
    );

    cursor_ctlfile #(.PTR_W(PTR_W)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ctl_we),
        .idx   (ptr_q),
        .wbyte (host_wdata[7:0]),
        .rbyte (ctl_rbyte),
        .regs  (regs)
    );

    cursor_patram #(.DEPTH(DEPTH), .DW(DW)) u_pat (
        .clk     (clk),
        .h_we    (pat_we),
        .h_addr  (ptr_q),
        .h_wdata (host_wdata),
        .h_rdata (pat_rdata),
        .p_addr  (pix_addr),
        .p_rdata (pix_data)
    );

    assign host_rvalid = rd_q.rvalid;
    assign host_rdata  = rd_q.from_pat ? pat_rdata : DW'(rd_q.rbyte);

    assign cur_en   = regs[IX_CMD][6];
    assign xhair_en = regs[IX_CMD][5];
    assign or_mode  = regs[IX_CMD][4];
    assign mux_sel  = regs[IX_CMD][3:2];
    assign thick    = regs[IX_CMD][1:0];
    assign cur_x    = CW'({regs[IX_CXHI][COORD_HI_BITS-1:0], regs[IX_CXLO]});
    assign cur_y    = CW'({regs[IX_CYHI][COORD_HI_BITS-1:0], regs[IX_CYLO]});
    assign win_x    = {regs[IX_WXHI], regs[IX_WXLO]};
    assign win_y    = {regs[IX_WYHI], regs[IX_WYLO]};
    assign win_w    = {regs[IX_WWHI], regs[IX_WWLO]};
    assign win_h    = {regs[IX_WHHI], regs[IX_WHLO]};

endmodule

// File: rtl/cursor_regport_chk.sv
module cursor_regport_chk #(
    parameter int PTR_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       host_port,
    input logic             host_wr,
    input logic             host_rd,
    input logic [15:0]      host_wdata,
    input logic [15:0]      host_rdata,
    input logic             host_rvalid,
    input logic [PTR_W-1:0] ptr,
    input logic [6:0]       cmd_bits,
    input logic [11:0]      cur_x,
    input logic [11:0]      cur_y
);
    logic data_acc, addr_wr;
    assign data_acc = (host_wr || host_rd) && host_port[1];
    assign addr_wr  = host_wr && !host_port[1];

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> ptr == PTR_W'($past(ptr) + 1'b1)); // R3

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_acc && !addr_wr) |=> $stable(ptr)); // R2

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && ptr == {PTR_W{1'b1}}) |=> ptr == '0); // R8

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_port == 2'd2 && ptr > PTR_W'(12)) |=> host_rdata == 16'h0); // R6

    AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_port == 2'd2 && ptr > PTR_W'(12)) |=> ($stable(cmd_bits) && $stable(cur_x) && $stable(cur_y))); // R6

    AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_port == 2'd2 && ptr == '0) |=> cmd_bits == $past(host_wdata[6:0])); // R11

    AST_NO_RVALID_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> !host_rvalid); // R12

endmodule

bind cursor_regport cursor_regport_chk #(.PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_port   (host_port),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .ptr         (ptr_q),
    .cmd_bits    ({cur_en, xhair_en, or_mode, mux_sel, thick}),
    .cur_x       (cur_x),
    .cur_y       (cur_y)
);

// File: tb/tb_cursor_regport.sv
module tb_cursor_regport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_port = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic [8:0]  pix_addr = '0;
    logic [15:0] pix_data;
    logic        cur_en, xhair_en, or_mode;
    logic [1:0]  mux_sel, thick;
    logic [11:0] cur_x, cur_y;
    logic [15:0] win_x, win_y, win_w, win_h;

    always #10 clk = ~clk;

    cursor_regport dut (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [8:0]  ptr_m;
    logic [7:0]  regs_m [13];
    logic [15:0] ram_m [512];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [1:0] p);
        case (p)
            2'd0: return {8'h00, ptr_m[7:0]};
            2'd1: return {15'h0, ptr_m[8]};
            2'd2: return (ptr_m < 13) ? {8'h00, regs_m[ptr_m]} : 16'h0;
            default: return ram_m[ptr_m];
        endcase
    endfunction

    task automatic access(input logic [1:0] p, input bit w, input bit r, input logic [15:0] d,
                          output logic [15:0] q, output logic v);
        @(negedge clk);
        host_port = p; host_wr = w; host_rd = r; host_wdata = d;
        @(negedge clk);
        q = host_rdata; v = host_rvalid;
        host_wr = 0; host_rd = 0;
    endtask

    task automatic model_write(input logic [1:0] p, input logic [15:0] d);
        case (p)
            2'd0: ptr_m[7:0] = d[7:0];
            2'd1: ptr_m[8] = d[0];
            2'd2: begin
                if (ptr_m < 13)
                    regs_m[ptr_m] = d[7:0] & ((ptr_m == 2 || ptr_m == 4) ? 8'h0F : 8'hFF);
                ptr_m++;
            end
            default: begin ram_m[ptr_m] = d; ptr_m++; end
        endcase
    endtask

    task automatic wr_port(input logic [1:0] p, input logic [15:0] d);
        logic [15:0] q; logic v;
        access(p, 1, 0, d, q, v);
        model_write(p, d);
        if (p == 2'd3) chk(v == 0, "R12 no rvalid after write", 32'(v), 0);
    endtask

    task automatic rd_port(input logic [1:0] p, input string req);
        logic [15:0] q, e; logic v;
        e = exp_read(p);
        access(p, 0, 1, 16'h0, q, v);
        chk(v == 1, "R12 rvalid after read", 32'(v), 1);
        chk(q == e, req, 32'(q), 32'(e));
        if (p[1]) ptr_m++;
    endtask

    task automatic set_ptr(input logic [8:0] a);
        wr_port(2'd0, {8'($urandom), a[7:0]});
        wr_port(2'd1, {15'($urandom), a[8]});
    endtask

    task automatic chk_outputs(input string req);
        logic [6:0] c;
        c = {cur_en, xhair_en, or_mode, mux_sel, thick};
        chk(c == regs_m[0][6:0], {req, " R11 cmd fields"}, 32'(c), 32'(regs_m[0][6:0]));
        chk(cur_x == {regs_m[2][3:0], regs_m[1]}, {req, " R5 cur_x"}, 32'(cur_x), 32'({regs_m[2][3:0], regs_m[1]}));
        chk(cur_y == {regs_m[4][3:0], regs_m[3]}, {req, " R5 cur_y"}, 32'(cur_y), 32'({regs_m[4][3:0], regs_m[3]}));
        chk(win_x == {regs_m[6], regs_m[5]}, {req, " R5 win_x"}, 32'(win_x), 32'({regs_m[6], regs_m[5]}));
        chk(win_y == {regs_m[8], regs_m[7]}, {req, " R5 win_y"}, 32'(win_y), 32'({regs_m[8], regs_m[7]}));
        chk(win_w == {regs_m[10], regs_m[9]}, {req, " R5 win_w"}, 32'(win_w), 32'({regs_m[10], regs_m[9]}));
        chk(win_h == {regs_m[12], regs_m[11]}, {req, " R5 win_h"}, 32'(win_h), 32'({regs_m[12], regs_m[11]}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    initial begin
        logic [15:0] q; logic v;
        void'($urandom(32'h5EED_0431));
        ptr_m = '0;
        for (int i = 0; i < 13; i++) regs_m[i] = '0;
        for (int i = 0; i < 512; i++) ram_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk_outputs("R1 reset");
        rd_port(2'd0, "R1 R2 pointer low after reset");
        rd_port(2'd1, "R1 R2 pointer high after reset");

        // R3 R5 R9 fill every control register in one run
        set_ptr(9'h000);
        for (int i = 0; i < 13; i++) wr_port(2'd2, 16'($urandom));
        @(negedge clk);
        chk_outputs("R3 run fill");
        rd_port(2'd0, "R3 pointer advanced to 13");
        // R4 read back run
        set_ptr(9'h000);
        for (int i = 0; i < 13; i++) rd_port(2'd2, "R4 R5 control read back");

        // R5 masked high bytes
        set_ptr(9'd2);
        wr_port(2'd2, 16'hFFFF);
        set_ptr(9'd2);
        rd_port(2'd2, "R5 cursor X high keeps 4 bits");

        // R6 out of range
        set_ptr(9'h00D);
        wr_port(2'd2, 16'h00FF);
        wr_port(2'd2, 16'h0055);
        @(negedge clk);
        chk_outputs("R6 out-of-range write");
        set_ptr(9'h0C0);
        rd_port(2'd2, "R6 out-of-range read zero");
        rd_port(2'd0, "R6 pointer still advances");

        // R8 wrap via control port
        set_ptr(9'h1FF);
        rd_port(2'd2, "R8 read at top");
        rd_port(2'd0, "R8 wrap low byte");
        rd_port(2'd1, "R8 wrap high bit");

        // R9 upper byte ignored on pointer ports
        wr_port(2'd0, 16'hA55C);
        wr_port(2'd1, 16'hFFFE);
        rd_port(2'd0, "R9 pointer low ignores upper byte");
        rd_port(2'd1, "R9 pointer high uses bit 0 only");

        // R7 R8 fill the whole pattern RAM, pointer returns to zero
        set_ptr(9'h000);
        for (int i = 0; i < 512; i++) wr_port(2'd3, 16'($urandom));
        rd_port(2'd0, "R8 pattern fill wraps low");
        rd_port(2'd1, "R8 pattern fill wraps high");
        set_ptr(9'h1FC);
        for (int i = 0; i < 8; i++) rd_port(2'd3, "R7 R8 pattern read across wrap");

        // R10 pixel port
        for (int i = 0; i < 20; i++) begin
            logic [8:0] a;
            a = 9'($urandom);
            @(negedge clk);
            pix_addr = a;
            @(negedge clk);
            chk(pix_data == ram_m[a], "R10 pixel read", 32'(pix_data), 32'(ram_m[a]));
        end

        // R12 simultaneous read and write: write only
        set_ptr(9'd5);
        access(2'd2, 1, 1, 16'h0077, q, v);
        model_write(2'd2, 16'h0077);
        chk(v == 0, "R12 no rvalid on write+read", 32'(v), 0);
        rd_port(2'd0, "R12 single pointer step");
        @(negedge clk);
        chk_outputs("R12 write took place");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0] p;
            p = 2'($urandom);
            if ($urandom % 6 == 0) set_ptr(($urandom % 3 == 0) ? 9'($urandom % 16) : 9'($urandom));
            if ($urandom % 2 == 0) begin
                if (p[1]) wr_port(p, 16'($urandom));
                else rd_port(p, "R2 random pointer read");
            end else begin
                rd_port(p, p == 2'd3 ? "R7 random pattern read" : "R4 R6 random read");
            end
        end
        @(negedge clk);
        chk_outputs("R3 after random mix");

        report();
    end
endmodule